// File: doc/BRIEF.md
# Nibble-Parallel CRC5 Engine

This block keeps a running 5-bit cyclic redundancy check over a stream of 4-bit data nibbles. It uses the generator polynomial x^5 + x^2 + 1. It absorbs one whole nibble per clock. The next-state logic is a single fixed XOR network. Its result is the same as clocking a bit-serial shift-register generator four times over the same bits. The network is not written out by hand. It is derived at elaboration time by superposition: the serial generator is run on every one-hot combination of state bit and data bit, and each response shows which inputs feed each output bit.

A synchronous reset loads the register with all ones. A data-valid strobe chooses between absorbing the nibble on `data` and holding the register. The current register value is always visible on `crc`. Final inversion, bit reflection and placing the check value into a packet are left to the surrounding logic.

Top module: `crc5n_engine`

## Requirements
- R1: The register is 5 bits wide, the data input is 4 bits wide, and the generator polynomial is x^5 + x^2 + 1. From the all-ones state, a zero nibble gives 5'h06 one cycle later.
- R2: When `rst` is high at a rising clock edge, `crc` reads 5'h1F after that edge. After any reset, `crc` never carries an unknown value.
- R3: When `rst` and `valid` are both high in the same cycle, the reset wins and `crc` reads 5'h1F.
- R4: When `valid` is low and `rst` is low, `crc` keeps its value whatever `data` carries.
- R5: When `valid` is high and `rst` is low, the new `crc` equals four steps of the serial generator. The data bits enter in the order `data[3]` first, then `data[2]`, `data[1]`, and `data[0]` last. One serial step works as follows: the feedback is crc[4] XOR the bit; the register shifts toward bit 4 with a zero entering bit 0; when the feedback is 1, bits 0 and 2 are inverted. From 5'h1F, nibble 4'hF gives 5'h10.
- R6: The parallel update, with s the old `crc` and d the nibble, is: n[0]=s1^s4^d0^d3, n[1]=s2^d1, n[2]=s1^s3^s4^d0^d2^d3, n[3]=s2^s4^d1^d3, n[4]=s0^s3^d2.
- R7: After a reset, `crc` equals the serial generator started from all ones and run over every accepted nibble in arrival order, each nibble MSB first. Cycles in which `valid` is low contribute nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads all ones |
| valid | input | 1 | High to absorb `data` at this edge |
| data | input | 4 | Data nibble; bit 3 is taken first |
| crc | output | 5 | Current CRC register value |

## Verification
The bench targets the bit order inside a nibble. A design that shifted `data[0]` in first would still give 5'h10 for nibble 4'hF, but it would fail on asymmetric nibbles in the random stream and against the R6 equations. The bench drives `rst` and `valid` together to expose a design that absorbs data during reset and leaves a value other than 5'h1F. It changes `data` while `valid` is low to catch a register that updates without the strobe. Long random streams with gaps and occasional resets compare the register with a serial model run over the whole accepted bit history. An error in one polynomial tap or in the feedback bit therefore shows up within a few nibbles.

// File: rtl/crc5n_pkg.sv
package crc5n_pkg;

    // Default geometry of the engine
    localparam int          CRC5N_W     = 5;
    localparam int          CRC5N_DW    = 4;
    // Low-order polynomial taps of x^5 + x^2 + 1 (the x^5 term is implicit)
    localparam logic [4:0]  CRC5N_POLY  = 5'h05;
    localparam logic [4:0]  CRC5N_SEED  = 5'h1F;

    // Action the register takes at the next edge
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_ABSORB = 2'd2
    } crc_op_e;

endpackage

// File: rtl/crc5n_response.sv
// Derives, per output bit, the set of inputs that feed it. The serial
// generator is run on each one-hot input (state bits first, then data bits)
// and every response is recorded. Result: a constant mask per output bit.
module crc5n_response #(
    parameter int                 CRC_W  = 5,
    parameter int                 DATA_W = 4,
    parameter logic [CRC_W-1:0]   POLY   = 5'h05,
    localparam int                IN_W   = CRC_W + DATA_W
) (
    output logic [CRC_W-1:0][IN_W-1:0] col_mask
);

    typedef logic [CRC_W-1:0][IN_W-1:0] mask_t;

    // Serial generator: data MSB first, shift toward the top bit.
    function automatic logic [CRC_W-1:0] serial_run(input logic [IN_W-1:0] stim);
        logic [CRC_W-1:0] st;
        logic             fb;
        st = stim[CRC_W-1:0];
        for (int j = DATA_W - 1; j >= 0; j--) begin
            fb = st[CRC_W-1] ^ stim[CRC_W+j];
            st = {st[CRC_W-2:0], 1'b0};
            if (fb) st = st ^ POLY;
        end
        return st;
    endfunction

    function automatic mask_t build_masks();
        mask_t            m;
        logic [IN_W-1:0]  onehot;
        logic [CRC_W-1:0] resp;
        m = '0;
        for (int k = 0; k < IN_W; k++) begin
            onehot    = '0;
            onehot[k] = 1'b1;
            resp      = serial_run(onehot);
            for (int i = 0; i < CRC_W; i++) begin
                m[i][k] = resp[i];
            end
        end
        return m;
    endfunction

    localparam mask_t MASKS = build_masks();

    assign col_mask = MASKS;

endmodule

// File: rtl/crc5n_xor_net.sv
// One XOR reduction per output bit over the inputs its mask selects.
module crc5n_xor_net #(
    parameter int  CRC_W  = 5,
    parameter int  DATA_W = 4,
    localparam int IN_W   = CRC_W + DATA_W
) (
    input  logic [CRC_W-1:0]            state,
    input  logic [DATA_W-1:0]           nib,
    input  logic [CRC_W-1:0][IN_W-1:0]  col_mask,
    output logic [CRC_W-1:0]            nxt
);

    logic [IN_W-1:0] joined;
    assign joined = {nib, state};

    for (genvar i = 0; i < CRC_W; i++) begin : g_out
        assign nxt[i] = ^(col_mask[i] & joined);
    end

endmodule

// File: rtl/crc5n_ctrl.sv
// Decodes the per-cycle action; reset outranks a data beat.
module crc5n_ctrl
    import crc5n_pkg::*;
(
    input  logic    rst,
    input  logic    valid,
    output crc_op_e op
);

    always_comb begin
        if (rst)        op = OP_LOAD;
        else if (valid) op = OP_ABSORB;
        else            op = OP_HOLD;
    end

endmodule

// File: rtl/crc5n_engine.sv
module crc5n_engine
    import crc5n_pkg::*;
#(
    parameter int               CRC_W  = CRC5N_W,
    parameter int               DATA_W = CRC5N_DW,
    parameter logic [CRC_W-1:0] POLY   = CRC5N_POLY,
    parameter logic [CRC_W-1:0] SEED   = CRC5N_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    localparam int IN_W = CRC_W + DATA_W;

    logic [CRC_W-1:0][IN_W-1:0] col_mask;
    logic [CRC_W-1:0]           crc_q;
    logic [CRC_W-1:0]           crc_nxt;
    crc_op_e                    op;

    crc5n_response #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) resp_i (
        .col_mask (col_mask)
    );

    crc5n_xor_net #(.CRC_W(CRC_W), .DATA_W(DATA_W)) net_i (
        .state    (crc_q),
        .nib      (data),
        .col_mask (col_mask),
        .nxt      (crc_nxt)
    );

    crc5n_ctrl ctrl_i (
        .rst   (rst),
        .valid (valid),
        .op    (op)
    );

    always_ff @(posedge clk) begin
        case (op)
            OP_LOAD:   crc_q <= SEED;
            OP_ABSORB: crc_q <= crc_nxt;
            default:   crc_q <= crc_q;
        endcase
    end

    assign crc = crc_q;

endmodule

// File: rtl/crc5n_checker.sv
module crc5n_checker #(
    parameter int               CRC_W  = 5,
    parameter int               DATA_W = 4,
    parameter logic [CRC_W-1:0] POLY   = 5'h05,
    parameter logic [CRC_W-1:0] SEED   = 5'h1F
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic [DATA_W-1:0] data,
    input logic [CRC_W-1:0]  crc
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // Bit-at-a-time reference, data MSB first
    function automatic logic [CRC_W-1:0] serial_ref(input logic [CRC_W-1:0] s,
                                                    input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] st;
        logic             fb;
        st = s;
        for (int j = DATA_W - 1; j >= 0; j--) begin
            fb = st[CRC_W-1] ^ d[j];
            st = {st[CRC_W-2:0], 1'b0};
            if (fb) st = st ^ POLY;
        end
        return st;
    endfunction

    p_seed_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(rst)) |-> (crc == SEED));

    p_known_value_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> !$isunknown(crc));

    p_reset_beats_data_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(rst) && $past(valid)) |-> (crc == SEED));

    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && !$past(valid)) |-> $stable(crc));

    p_serial_match_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(rst) && $past(valid)) |->
            (crc == serial_ref($past(crc), $past(data))));

endmodule

bind crc5n_engine crc5n_checker #(
    .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .SEED(SEED)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .valid (valid),
    .data  (data),
    .crc   (crc)
);

// File: tb/crc5n_engine_tb_top.sv
`timescale 1ns/1ps
module crc5n_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       valid;
    logic [3:0] data;
    logic [4:0] crc;

    int vectors = 0;
    int errs    = 0;
    bit bitq[$];
    int eq_state;

    always #4 clk = ~clk;   // 125 MHz

    crc5n_engine dut_i (
        .clk   (clk),
        .rst   (rst),
        .valid (valid),
        .data  (data),
        .crc   (crc)
    );

    // Serial model over the whole accepted bit history
    function automatic int serial_of_history();
        int c;
        int fb;
        c = 31;
        foreach (bitq[i]) begin
            fb = ((c >> 4) & 1) ^ int'(bitq[i]);
            c  = (c << 1) & 31;
            if (fb != 0) c = c ^ 5;
        end
        return c;
    endfunction

    // Parallel equations as stated in R6
    function automatic int eq_next(int s, int d);
        int n0, n1, n2, n3, n4;
        n0 = s>>1 ^ s>>4 ^ d ^ d>>3;
        n1 = s>>2 ^ d>>1;
        n2 = s>>1 ^ s>>3 ^ s>>4 ^ d ^ d>>2 ^ d>>3;
        n3 = s>>2 ^ s>>4 ^ d>>1 ^ d>>3;
        n4 = s ^ s>>3 ^ d>>2;
        return (n0 & 1) | ((n1 & 1) << 1) | ((n2 & 1) << 2) | ((n3 & 1) << 3) | ((n4 & 1) << 4);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: crc=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, check
    task automatic step(input bit r, input bit v, input logic [3:0] d);
        int prev;
        prev  = int'(crc);
        rst   = r;
        valid = v;
        data  = d;
        @(negedge clk);
        if (r) begin
            bitq.delete();
            eq_state = 31;
            check(crc === 5'h1F, v ? "R3 reset over data" : "R2 reset seed", int'(crc), 31);
        end else if (v) begin
            for (int j = 3; j >= 0; j--) bitq.push_back(d[j]);
            eq_state = eq_next(eq_state, int'(d));
            check(int'(crc) == serial_of_history(), "R7 stream vs serial", int'(crc), serial_of_history());
            check(int'(crc) == eq_state, "R6 parallel equations", int'(crc), eq_state);
        end else begin
            check(int'(crc) == prev, "R4 hold when idle", int'(crc), prev);
        end
    endtask

    initial begin
        #1600000;
        errs++;
        $display("FAIL watchdog: crc=%02h expected=finish", crc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        rst = 1'b1; valid = 1'b0; data = 4'h0;
        @(negedge clk);
        step(1'b1, 1'b0, 4'h0);                         // R2

        step(1'b0, 1'b1, 4'h0);                         // R1: zero nibble
        check(crc === 5'h06, "R1 zero nibble from seed", int'(crc), 6);

        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 4'(i * 3 + 5));   // R4
        check(crc === 5'h06, "R4 value kept over idle", int'(crc), 6);

        step(1'b0, 1'b1, 4'h9);
        step(1'b1, 1'b1, 4'hA);                         // R3
        check(crc === 5'h1F, "R3 reset wins", int'(crc), 31);

        step(1'b0, 1'b1, 4'hF);                         // R5
        check(crc === 5'h10, "R5 nibble F from seed", int'(crc), 16);

        step(1'b1, 1'b0, 4'h0);
        step(1'b0, 1'b1, 4'h1);                         // R5 bit order, asymmetric
        check(int'(crc) == serial_of_history(), "R5 nibble 1 MSB-first", int'(crc), serial_of_history());
        step(1'b0, 1'b1, 4'h8);
        check(int'(crc) == serial_of_history(), "R5 nibble 8 MSB-first", int'(crc), serial_of_history());

        for (int i = 0; i < 3000; i++) begin
            int roll;
            roll = $urandom_range(0, 99);
            step(roll < 2, roll < 72, 4'($urandom_range(0, 15)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule